// File: doc/BRIEF.md
# Channel Interrupt and Reset Sequencer

This block is the control core of one processing channel in a descriptor-driven accelerator. It turns descriptor outcomes into interrupt events for a central controller. A successful descriptor completion can raise a done event. A detected processing fault raises an error interrupt, and the block latches its code. The channel applies no mask of its own, because masking happens downstream. Done events that arrive faster than the host services them are held in a small saturating pending count. The done interrupt stays high while that count is non-zero.

The block also carries out a software-requested channel reset. The steps of the reset depend on which execution units the channel holds. If no primary unit is assigned, the channel is still waiting for one, so it only cancels its request and clears itself. If a primary unit is assigned, the channel asks for a reset write to that unit and waits for the acknowledge. If a secondary snooping hash unit is also reserved, that unit gets a reset write of its own. After the writes, the channel releases its units, clears its state and the reset bit, and returns to idle.

The sequencer has six states. SEQ_IDLE is normal operation. SEQ_CANCEL releases a pending request. SEQ_WR_PRIM and SEQ_WR_SEC hold the reset-write requests to the primary and secondary units. SEQ_RELEASE returns the reserved units. SEQ_CLEAR wipes the state and pulses the reset-bit clear. The transitions are:
- IDLE→CANCEL: reset requested with no primary unit assigned.
- IDLE→WR_PRIM: reset requested with a primary unit assigned.
- WR_PRIM→WR_SEC: acknowledge received with a secondary unit reserved.
- WR_PRIM→RELEASE: acknowledge received with no secondary unit.
- WR_SEC→RELEASE: acknowledge received.
- CANCEL→CLEAR and RELEASE→CLEAR: unconditional.
- CLEAR→IDLE: unconditional.

Top module: `chan_irq_rst_seq`

## Requirements
- R1: With done enable high and notify-global high, each cycle with `desc_done_ok` high in SEQ_IDLE adds one to `done_pend`. The new value is visible after the next rising edge.
- R2: With done enable high and notify-global low, a completion counts only when `desc_notify` is high in the same cycle.
- R3: With done enable low, a completion never changes `done_pend`.
- R4: `done_irq` is high exactly when `done_pend` is non-zero. `host_done_clr` lowers the count by one and has no effect at zero. A counted event and a clear in the same cycle leave the count unchanged.
- R5: `done_pend` saturates at 15. Further events leave it at 15.
- R6: An error strobe in SEQ_IDLE with no error pending has two effects after the next edge: `err_irq` goes high and `err_status` takes `err_code`. While the error is pending, further error strobes leave `err_status` unchanged. `host_err_clr` drops `err_irq` after the next edge, and `err_status` keeps its value.
- R7: A reset request in SEQ_IDLE with `prim_assigned` low gives one SEQ_CANCEL cycle with `rel_prim` and `rel_sec` both high. One SEQ_CLEAR cycle with `reset_done` high follows, and then SEQ_IDLE. No reset write is issued.
- R8: A reset request with `prim_assigned` high raises `rst_wr_req` with `rst_wr_sel`=0 (primary) until `rst_wr_ack`. If a secondary unit is reserved, the request then stays high with `rst_wr_sel`=1 until the next `rst_wr_ack`. One SEQ_RELEASE cycle follows with `rel_prim` high and `rel_sec` high only when a secondary unit is reserved. One SEQ_CLEAR cycle follows that.
- R9: A completed SEQ_CLEAR sets `done_pend` to 0, `err_irq` to 0 and `err_status` to 0.
- R10: While the sequencer is outside SEQ_IDLE, completion and error strobes are ignored.
- R11: Whether a secondary unit is reserved is sampled when the reset starts. A later change of `sec_reserved` does not alter the sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low hardware reset |
| cfg_done_en | input | 1 | Done-interrupt enable |
| cfg_notify_global | input | 1 | 1: notify on every completion; 0: only flagged descriptors |
| cfg_reset_req | input | 1 | Software channel-reset bit |
| desc_done_ok | input | 1 | Descriptor completed successfully (strobe) |
| desc_notify | input | 1 | Done-notify flag of the completing descriptor |
| err_detect | input | 1 | Error detected (strobe) |
| err_code | input | ERR_W | Type of detected error |
| host_done_clr | input | 1 | Host services one done event |
| host_err_clr | input | 1 | Host clears the error interrupt |
| prim_assigned | input | 1 | A primary execution unit is assigned |
| sec_reserved | input | 1 | A secondary snooping unit is reserved |
| rst_wr_ack | input | 1 | Reset write accepted |
| done_irq | output | 1 | Done interrupt, high while events are pending |
| done_pend | output | CNT_W | Pending done-event count |
| err_irq | output | 1 | Error interrupt |
| err_status | output | ERR_W | Latched error code |
| rst_wr_req | output | 1 | Request for a unit reset write |
| rst_wr_sel | output | 1 | 0: primary unit, 1: secondary unit |
| rel_prim | output | 1 | Release / cancel primary unit |
| rel_sec | output | 1 | Release / cancel secondary unit |
| reset_done | output | 1 | Reset finished; clears the reset bit |

## Verification
The hardest case to reach is a full reset that covers both units. It needs the sampled secondary flag, acknowledges that arrive several cycles late, descriptor strobes inside the sequence, and state to be wiped. The bench fills the pending count and latches an error before it starts that reset. It holds off each acknowledge for several cycles and toggles `sec_reserved` while the writes are in flight. A behavioural reference model runs alongside and is compared with the design on every clock, so the cycle in which each step happens is checked as well as the final state.

// File: rtl/chan_seq_pkg.sv
package chan_seq_pkg;
    typedef enum logic [2:0] {
        SEQ_IDLE,
        SEQ_CANCEL,
        SEQ_WR_PRIM,
        SEQ_WR_SEC,
        SEQ_RELEASE,
        SEQ_CLEAR
    } seq_state_e;
endpackage

// File: rtl/done_pend_counter.sv
module done_pend_counter #(
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             inc,
    input  logic             dec,
    input  logic             wipe,
    output logic [CNT_W-1:0] cnt
);
    localparam logic [CNT_W-1:0] MAXV = '1;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (wipe) begin
            cnt <= '0;
        end else if (inc && !dec) begin
            if (cnt != MAXV) cnt <= cnt + 1'b1;
        end else if (dec && !inc) begin
            if (cnt != '0) cnt <= cnt - 1'b1;
        end
    end

    assert_no_overflow_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt == MAXV && inc && !dec && !wipe) |=> (cnt == MAXV));

    assert_no_underflow_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt == '0 && dec && !inc) |=> (cnt == '0));
endmodule

// File: rtl/err_latch.sv
module err_latch #(
    parameter int ERR_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             detect,
    input  logic [ERR_W-1:0] code_in,
    input  logic             clr,
    input  logic             wipe,
    output logic             pend,
    output logic [ERR_W-1:0] code
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pend <= 1'b0;
            code <= '0;
        end else if (wipe) begin
            pend <= 1'b0;
            code <= '0;
        end else if (clr) begin
            pend <= 1'b0;
        end else if (detect && !pend) begin
            pend <= 1'b1;
            code <= code_in;
        end
    end

    assert_code_stable_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (pend && !wipe) |=> $stable(code));
endmodule

// File: rtl/chan_reset_fsm.sv
module chan_reset_fsm
    import chan_seq_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic reset_req,
    input  logic prim_assigned,
    input  logic sec_reserved,
    input  logic wr_ack,
    output logic busy,
    output logic wr_req,
    output logic wr_sel,
    output logic rel_prim,
    output logic rel_sec,
    output logic clr_pulse
);
    seq_state_e state, state_nx;
    logic       sec_q;

    always_comb begin
        state_nx = state;
        unique case (state)
            SEQ_IDLE:    if (reset_req) state_nx = prim_assigned ? SEQ_WR_PRIM : SEQ_CANCEL;
            SEQ_CANCEL:  state_nx = SEQ_CLEAR;
            SEQ_WR_PRIM: if (wr_ack) state_nx = sec_q ? SEQ_WR_SEC : SEQ_RELEASE;
            SEQ_WR_SEC:  if (wr_ack) state_nx = SEQ_RELEASE;
            SEQ_RELEASE: state_nx = SEQ_CLEAR;
            SEQ_CLEAR:   state_nx = SEQ_IDLE;
            default:     state_nx = SEQ_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= SEQ_IDLE;
            sec_q <= 1'b0;
        end else begin
            state <= state_nx;
            if (state == SEQ_IDLE && reset_req) sec_q <= sec_reserved;
        end
    end

    always_comb begin
        busy      = (state != SEQ_IDLE);
        wr_req    = 1'b0;
        wr_sel    = 1'b0;
        rel_prim  = 1'b0;
        rel_sec   = 1'b0;
        clr_pulse = 1'b0;
        unique case (state)
            SEQ_IDLE:    ;
            SEQ_CANCEL:  begin rel_prim = 1'b1; rel_sec = 1'b1; end
            SEQ_WR_PRIM: wr_req = 1'b1;
            SEQ_WR_SEC:  begin wr_req = 1'b1; wr_sel = 1'b1; end
            SEQ_RELEASE: begin rel_prim = 1'b1; rel_sec = sec_q; end
            SEQ_CLEAR:   clr_pulse = 1'b1;
            default:     ;
        endcase
    end

    assert_prim_before_sec_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (state == SEQ_WR_SEC) |-> ($past(state) == SEQ_WR_PRIM || $past(state) == SEQ_WR_SEC));

    assert_wait_ack_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (state == SEQ_WR_PRIM && !wr_ack) |=> (state == SEQ_WR_PRIM));

    assert_cancel_path_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (state == SEQ_CANCEL) |=> (state == SEQ_CLEAR));

    assert_release_onehot_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({wr_req, clr_pulse, rel_prim}));
endmodule

// File: rtl/chan_irq_rst_seq.sv
module chan_irq_rst_seq #(
    parameter int CNT_W = 4,
    parameter int ERR_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_done_en,
    input  logic             cfg_notify_global,
    input  logic             cfg_reset_req,
    input  logic             desc_done_ok,
    input  logic             desc_notify,
    input  logic             err_detect,
    input  logic [ERR_W-1:0] err_code,
    input  logic             host_done_clr,
    input  logic             host_err_clr,
    input  logic             prim_assigned,
    input  logic             sec_reserved,
    input  logic             rst_wr_ack,
    output logic             done_irq,
    output logic [CNT_W-1:0] done_pend,
    output logic             err_irq,
    output logic [ERR_W-1:0] err_status,
    output logic             rst_wr_req,
    output logic             rst_wr_sel,
    output logic             rel_prim,
    output logic             rel_sec,
    output logic             reset_done
);
    logic busy;
    logic done_evt;
    logic err_evt;

    chan_reset_fsm u_fsm (
        .clk           (clk),
        .rst_n         (rst_n),
        .reset_req     (cfg_reset_req),
        .prim_assigned (prim_assigned),
        .sec_reserved  (sec_reserved),
        .wr_ack        (rst_wr_ack),
        .busy          (busy),
        .wr_req        (rst_wr_req),
        .wr_sel        (rst_wr_sel),
        .rel_prim      (rel_prim),
        .rel_sec       (rel_sec),
        .clr_pulse     (reset_done)
    );

    // qualify completion by enable and notification type; ignored while sequencing
    assign done_evt = desc_done_ok && cfg_done_en && (cfg_notify_global || desc_notify) && !busy;
    assign err_evt  = err_detect && !busy;

    done_pend_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk   (clk),
        .rst_n (rst_n),
        .inc   (done_evt),
        .dec   (host_done_clr),
        .wipe  (reset_done),
        .cnt   (done_pend)
    );

    err_latch #(.ERR_W(ERR_W)) u_err (
        .clk     (clk),
        .rst_n   (rst_n),
        .detect  (err_evt),
        .code_in (err_code),
        .clr     (host_err_clr),
        .wipe    (reset_done),
        .pend    (err_irq),
        .code    (err_status)
    );

    assign done_irq = (done_pend != '0);

    assert_wipe_R9: assert property (@(posedge clk) disable iff (!rst_n)
        reset_done |=> (done_pend == '0 && !err_irq && err_status == '0));

    assert_busy_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !reset_done && !host_done_clr) |=> $stable(done_pend));
endmodule

// File: tb/chan_irq_rst_seq_bench.sv
module chan_irq_rst_seq_bench;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cfg_done_en = 0, cfg_notify_global = 0, rst_bit = 0;
    logic desc_done_ok = 0, desc_notify = 0, err_detect = 0;
    logic [3:0] err_code = 0;
    logic host_done_clr = 0, host_err_clr = 0;
    logic prim_assigned = 0, sec_reserved = 0, rst_wr_ack = 0;
    logic done_irq, err_irq, rst_wr_req, rst_wr_sel, rel_prim, rel_sec, reset_done;
    logic [3:0] done_pend, err_status;

    int checks = 0, fails = 0;
    bit finished = 0;
    int m_state = 0, m_cnt = 0, m_err = 0, m_code = 0, m_sec = 0;

    always #5 clk = ~clk;

    chan_irq_rst_seq u_chan_irq_rst_seq (
        .clk(clk), .rst_n(rst_n), .cfg_done_en(cfg_done_en),
        .cfg_notify_global(cfg_notify_global), .cfg_reset_req(rst_bit),
        .desc_done_ok(desc_done_ok), .desc_notify(desc_notify),
        .err_detect(err_detect), .err_code(err_code),
        .host_done_clr(host_done_clr), .host_err_clr(host_err_clr),
        .prim_assigned(prim_assigned), .sec_reserved(sec_reserved),
        .rst_wr_ack(rst_wr_ack), .done_irq(done_irq), .done_pend(done_pend),
        .err_irq(err_irq), .err_status(err_status), .rst_wr_req(rst_wr_req),
        .rst_wr_sel(rst_wr_sel), .rel_prim(rel_prim), .rel_sec(rel_sec),
        .reset_done(reset_done)
    );

    // behavioural reference: phase 0 idle,1 cancel,2 prim write,3 sec write,4 release,5 clear
    always @(posedge clk) begin
        if (!rst_n) begin
            m_state = 0; m_cnt = 0; m_err = 0; m_code = 0; m_sec = 0;
        end else begin
            bit busy, ev, wipe;
            busy = (m_state != 0);
            wipe = (m_state == 5);
            ev = !busy && desc_done_ok && cfg_done_en && (cfg_notify_global || desc_notify);
            if (wipe) m_cnt = 0;
            else if (ev && !host_done_clr) m_cnt = (m_cnt < 15) ? m_cnt + 1 : 15;
            else if (host_done_clr && !ev && m_cnt > 0) m_cnt = m_cnt - 1;
            if (wipe) begin m_err = 0; m_code = 0; end
            else if (host_err_clr) m_err = 0;
            else if (err_detect && !busy && m_err == 0) begin m_err = 1; m_code = int'(err_code); end
            case (m_state)
                0: if (rst_bit) begin m_state = prim_assigned ? 2 : 1; m_sec = sec_reserved; end
                1: m_state = 5;
                2: if (rst_wr_ack) m_state = (m_sec != 0) ? 3 : 4;
                3: if (rst_wr_ack) m_state = 4;
                4: m_state = 5;
                default: m_state = 0;
            endcase
        end
    end

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic compare_all();
        chk("R4 done_irq", int'(done_irq), (m_cnt != 0) ? 1 : 0);
        chk("R1 done_pend", int'(done_pend), m_cnt);
        chk("R6 err_irq", int'(err_irq), m_err);
        chk("R6 err_status", int'(err_status), m_code);
        chk("R8 rst_wr_req", int'(rst_wr_req), (m_state == 2 || m_state == 3) ? 1 : 0);
        chk("R8 rst_wr_sel", int'(rst_wr_sel), (m_state == 3) ? 1 : 0);
        chk("R7 rel_prim", int'(rel_prim), (m_state == 1 || m_state == 4) ? 1 : 0);
        chk("R7 rel_sec", int'(rel_sec), (m_state == 1 || (m_state == 4 && m_sec != 0)) ? 1 : 0);
        chk("R9 reset_done", int'(reset_done), (m_state == 5) ? 1 : 0);
    endtask

    task automatic cyc(input int n = 1);
        for (int i = 0; i < n; i++) begin
            @(posedge clk);
            @(negedge clk);
            compare_all();
            if (reset_done) rst_bit = 0;
        end
    endtask

    task automatic done_pulse(input bit flag);
        desc_done_ok = 1; desc_notify = flag; cyc(); desc_done_ok = 0; desc_notify = 0;
    endtask

    task automatic run_reset(input int ack_wait);
        rst_bit = 1;
        for (int k = 0; k < 40 && rst_bit; k++) begin
            rst_wr_ack = (rst_wr_req && k % (ack_wait + 1) == ack_wait);
            if (k == 3) sec_reserved = ~sec_reserved;   // R11 late change
            desc_done_ok = 1; desc_notify = 1; err_detect = 1; err_code = 4'hE; // R10 strobes
            cyc();
        end
        rst_wr_ack = 0; desc_done_ok = 0; desc_notify = 0; err_detect = 0;
        cyc();
    endtask

    initial begin
        #2_000_000;
        if (!finished) begin
            checks++; fails++;
            $display("FAIL watchdog expired");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
            $finish;
        end
    end

    initial begin
        cyc(2);
        rst_n = 1;
        cyc();
        chk("R4 reset state done_pend", int'(done_pend), 0);

        // R1 global notification
        cfg_done_en = 1; cfg_notify_global = 1;
        done_pulse(0); done_pulse(1); done_pulse(0);
        chk("R1 three global events", int'(done_pend), 3);
        host_done_clr = 1; cyc(); host_done_clr = 0;
        chk("R4 clear decrements", int'(done_pend), 2);
        host_done_clr = 1; desc_done_ok = 1; cyc(); host_done_clr = 0; desc_done_ok = 0;
        chk("R4 inc and dec together", int'(done_pend), 2);
        host_done_clr = 1; cyc(3); host_done_clr = 0;
        chk("R4 clear at zero", int'(done_pend), 0);
        chk("R4 irq low at zero", int'(done_irq), 0);

        // R2 per-descriptor
        cfg_notify_global = 0;
        done_pulse(0); done_pulse(1); done_pulse(0); done_pulse(1);
        chk("R2 only flagged counted", int'(done_pend), 2);

        // R3 disabled
        cfg_done_en = 0; cfg_notify_global = 1;
        done_pulse(1); done_pulse(0);
        chk("R3 disabled no change", int'(done_pend), 2);

        // R5 saturation
        cfg_done_en = 1;
        for (int i = 0; i < 18; i++) done_pulse(0);
        chk("R5 saturated", int'(done_pend), 15);

        // R6 error
        err_detect = 1; err_code = 4'h5; cyc(); err_detect = 0;
        chk("R6 err latched", int'(err_status), 5);
        err_detect = 1; err_code = 4'h9; cyc(2); err_detect = 0;
        chk("R6 code held", int'(err_status), 5);
        host_err_clr = 1; cyc(); host_err_clr = 0;
        chk("R6 cleared", int'(err_irq), 0);
        err_detect = 1; err_code = 4'h3; cyc(); err_detect = 0;
        chk("R6 new error", int'(err_status), 3);

        // R7 cancel path
        prim_assigned = 0;
        run_reset(0);
        chk("R9 count wiped after cancel", int'(done_pend), 0);

        // R8 primary only, slow ack
        done_pulse(0); err_detect = 1; err_code = 4'h7; cyc(); err_detect = 0;
        prim_assigned = 1; sec_reserved = 0;
        run_reset(3);
        chk("R9 error wiped", int'(err_status), 0);

        // R8/R11 primary and secondary, slow ack, events during sequence
        for (int i = 0; i < 6; i++) done_pulse(1);
        err_detect = 1; err_code = 4'hA; cyc(); err_detect = 0;
        sec_reserved = 1;
        run_reset(4);
        chk("R10 busy events dropped", int'(done_pend), 0);
        chk("R10 busy error dropped", int'(err_irq), 0);

        // R11 secondary reserved at start is low, rises later
        prim_assigned = 1; sec_reserved = 0;
        run_reset(1);
        done_pulse(0);
        chk("R1 works after reset", int'(done_pend), 1);

        finished = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end
endmodule